// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits between a bus master and a memory or peripheral port. It looks at each request the master makes. A request inside a configured alias window is turned into an operation on a single bit of a target region. Each bit of the target region owns one 32-bit word in the alias window.

Reading an alias word returns the selected target bit in bit 0. Writing an alias word runs a locked read-modify-write on the target. That sequence sets or clears only the chosen bit, and it keeps the access size the master used. Requests outside the window are forwarded unchanged.

A parameter can mark the target region as reachable by full-word accesses only. In that case, narrower alias requests never reach the target.

Both request channels use valid/ready handshakes. A request whose valid is high must hold its address, write flag, size and data stable until ready is seen high on a clock edge. The master port takes one request at a time. `m_req_ready` is high only while the block is idle, so the master is held off for the whole translated sequence. Responses on both sides are single-cycle valid pulses and cannot be back-pressured.

Top module: `bitband_bridge`

## Requirements
- R1: A request outside the alias window is sent to the target with the same address, write flag, size and write data. The target's read data and error flag are returned to the master unchanged.
- R2: An address A inside the window, with offset O = A - ALIAS_BASE, selects the target word at TARGET_BASE + (O >> 7) * 4. The bit inside that word is O[6:2].
- R3: An alias read returns the selected target bit in response bit 0, and response bits 31:1 are zero.
- R4: On an alias write, bit 0 of the write data sets (1) or clears (0) the selected bit. All other write-data bits are ignored, and every other target bit keeps its value.
- R5: Every target access made for an alias request carries the master's size code: 0 = byte, 1 = halfword, 2 = word. Data is right-aligned in bits 7:0, 15:0 or 31:0.
- R6: The target address depends on the alias size. For a byte access it is the word address plus (bit / 8), with bit position (bit mod 8). For a halfword access it is the word address plus 2 * (bit / 16), with bit position (bit mod 16).
- R7: An alias write holds `s_lock` high across both target cycles, and the master receives exactly one response, after the write-back completes.
- R8: An error on the read phase of an alias write cancels the write-back, and the error is returned to the master.
- R9: With WORD_ONLY set, a non-word alias request issues no target request. It is answered with error 1 and read data 0.
- R10: A target request is held stable while `s_req_ready` is low. While `m_req_ready` is high, neither `s_req_valid` nor `m_rsp_valid` is asserted.
- R11: After reset, `m_req_ready` is 1, and `m_rsp_valid` and `s_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Block accepts a master request |
| m_req_addr | input | 32 | Master byte address |
| m_req_write | input | 1 | 1 = write |
| m_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| m_req_wdata | input | 32 | Right-aligned write data |
| m_rsp_valid | output | 1 | Response pulse to master |
| m_rsp_rdata | output | 32 | Response read data |
| m_rsp_err | output | 1 | Response error flag |
| s_req_valid | output | 1 | Target request valid |
| s_req_ready | input | 1 | Target accepts request |
| s_req_addr | output | 32 | Target byte address |
| s_req_write | output | 1 | Target write flag |
| s_req_size | output | 2 | Target size code |
| s_req_wdata | output | 32 | Target write data |
| s_lock | output | 1 | Read-modify-write in progress |
| s_rsp_valid | input | 1 | Target response pulse |
| s_rsp_rdata | input | 32 | Target read data |
| s_rsp_err | input | 1 | Target error flag |

## Verification
The bench builds two instances, each with a 256-byte target region. The first has WORD_ONLY = 0 and is driven by a byte-array memory model with pseudo-random ready stalls and an error band at the top of the region. That instance brings byte, halfword and word alias mapping, stalled handshakes and read-phase aborts within reach. The second has WORD_ONLY = 1 and exposes the word-only rule, where a narrow alias access must leave the target port idle.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TREQ  = 2'd1,
    ST_TWAIT = 2'd2,
    ST_RESP  = 2'd3
  } bb_state_e;

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE  = 32'h2000_0000,
  parameter int          TARGET_BYTES = 1024
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  output logic        hit,
  output logic [31:0] tgt_addr,
  output logic [4:0]  bit_pos
);
  localparam logic [31:0] ALIAS_BYTES = 32'(TARGET_BYTES) * 32'd32;

  logic [31:0] off;
  logic [31:0] word_addr;
  logic [4:0]  bitn;

  always_comb begin
    off       = addr - ALIAS_BASE;
    hit       = off < ALIAS_BYTES;
    bitn      = off[6:2];
    word_addr = TARGET_BASE + {5'd0, off[31:7], 2'b00};
    case (size)
      SZ_BYTE: begin
        tgt_addr = word_addr + {30'd0, bitn[4:3]};
        bit_pos  = {2'b00, bitn[2:0]};
      end
      SZ_HALF: begin
        tgt_addr = word_addr + {30'd0, bitn[4], 1'b0};
        bit_pos  = {1'b0, bitn[3:0]};
      end
      default: begin
        tgt_addr = word_addr;
        bit_pos  = bitn;
      end
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [1:0]  size,
  input  logic [4:0]  pos,
  input  logic        set,
  output logic        bit_val,
  output logic [31:0] wdata
);
  logic [31:0] sel;

  always_comb begin
    sel     = 32'd1 << pos;
    bit_val = rdata[pos];
    wdata   = (set ? (rdata | sel) : (rdata & ~sel)) & lane_mask(size);
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE  = 32'h2000_0000,
  parameter int          TARGET_BYTES = 1024,
  parameter int          WORD_ONLY    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_req_valid,
  output logic        m_req_ready,
  input  logic [31:0] m_req_addr,
  input  logic        m_req_write,
  input  logic [1:0]  m_req_size,
  input  logic [31:0] m_req_wdata,
  output logic        m_rsp_valid,
  output logic [31:0] m_rsp_rdata,
  output logic        m_rsp_err,
  output logic        s_req_valid,
  input  logic        s_req_ready,
  output logic [31:0] s_req_addr,
  output logic        s_req_write,
  output logic [1:0]  s_req_size,
  output logic [31:0] s_req_wdata,
  output logic        s_lock,
  input  logic        s_rsp_valid,
  input  logic [31:0] s_rsp_rdata,
  input  logic        s_rsp_err
);
  bb_state_e   state_q;
  logic        alias_q, wr_q, set_q, phase_wr_q, err_q;
  logic [1:0]  size_q;
  logic [4:0]  pos_q;
  logic [31:0] taddr_q, wdata_q, rdata_q;

  logic        dec_hit;
  logic [31:0] dec_tgt;
  logic [4:0]  dec_pos;
  logic        mrg_bit;
  logic [31:0] mrg_wdata;
  logic        narrow_block;

  bb_alias_decode #(
    .ALIAS_BASE  (ALIAS_BASE),
    .TARGET_BASE (TARGET_BASE),
    .TARGET_BYTES(TARGET_BYTES)
  ) u_decode (
    .addr    (m_req_addr),
    .size    (m_req_size),
    .hit     (dec_hit),
    .tgt_addr(dec_tgt),
    .bit_pos (dec_pos)
  );

  bb_bit_merge u_merge (
    .rdata  (s_rsp_rdata),
    .size   (size_q),
    .pos    (pos_q),
    .set    (set_q),
    .bit_val(mrg_bit),
    .wdata  (mrg_wdata)
  );

  assign narrow_block = dec_hit && (WORD_ONLY != 0) && (m_req_size != SZ_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      alias_q    <= 1'b0;
      wr_q       <= 1'b0;
      set_q      <= 1'b0;
      phase_wr_q <= 1'b0;
      err_q      <= 1'b0;
      size_q     <= SZ_BYTE;
      pos_q      <= 5'd0;
      taddr_q    <= 32'd0;
      wdata_q    <= 32'd0;
      rdata_q    <= 32'd0;
    end else begin
      case (state_q)
        ST_IDLE: if (m_req_valid) begin
          alias_q <= dec_hit;
          wr_q    <= m_req_write;
          size_q  <= m_req_size;
          set_q   <= m_req_wdata[0];
          pos_q   <= dec_pos;
          if (dec_hit) begin
            taddr_q    <= dec_tgt;
            phase_wr_q <= 1'b0;
            wdata_q    <= 32'd0;
          end else begin
            taddr_q    <= m_req_addr;
            phase_wr_q <= m_req_write;
            wdata_q    <= m_req_wdata;
          end
          if (narrow_block) begin
            rdata_q <= 32'd0;
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_TREQ;
          end
        end
        ST_TREQ: if (s_req_ready) state_q <= ST_TWAIT;
        ST_TWAIT: if (s_rsp_valid) begin
          if (alias_q && wr_q && !phase_wr_q && !s_rsp_err) begin
            phase_wr_q <= 1'b1;
            wdata_q    <= mrg_wdata;
            state_q    <= ST_TREQ;
          end else begin
            err_q   <= s_rsp_err;
            rdata_q <= !alias_q ? s_rsp_rdata :
                       (wr_q ? 32'd0 : {31'd0, mrg_bit});
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign m_req_ready = (state_q == ST_IDLE);
  assign m_rsp_valid = (state_q == ST_RESP);
  assign m_rsp_rdata = rdata_q;
  assign m_rsp_err   = err_q;
  assign s_req_valid = (state_q == ST_TREQ);
  assign s_req_addr  = taddr_q;
  assign s_req_write = phase_wr_q;
  assign s_req_size  = size_q;
  assign s_req_wdata = wdata_q;
  assign s_lock      = alias_q && wr_q &&
                       ((state_q == ST_TREQ) || (state_q == ST_TWAIT));
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter int          TARGET_BYTES = 1024,
  parameter int          WORD_ONLY    = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        m_req_valid,
  input logic        m_req_ready,
  input logic [31:0] m_req_addr,
  input logic        m_req_write,
  input logic [1:0]  m_req_size,
  input logic        m_rsp_valid,
  input logic [31:0] m_rsp_rdata,
  input logic        s_req_valid,
  input logic        s_req_ready,
  input logic [31:0] s_req_addr,
  input logic        s_req_write,
  input logic [1:0]  s_req_size,
  input logic [31:0] s_req_wdata,
  input logic        s_lock
);
  localparam logic [31:0] WIN = 32'(TARGET_BYTES) * 32'd32;
  logic       c_alias, c_write;
  logic [1:0] c_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_alias <= 1'b0;
      c_write <= 1'b0;
      c_size  <= 2'd0;
    end else if (m_req_valid && m_req_ready) begin
      c_alias <= (m_req_addr - ALIAS_BASE) < WIN;
      c_write <= m_req_write;
      c_size  <= m_req_size;
    end
  end

  // R5
  size_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid |-> s_req_size == c_size);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && !s_req_ready |=> s_req_valid && $stable(s_req_addr) &&
      $stable(s_req_wdata) && $stable(s_req_write));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_ready |-> !s_req_valid && !m_rsp_valid);

  // R3
  alias_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid && c_alias && !c_write |-> m_rsp_rdata[31:1] == 31'd0);

  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && s_req_write && c_alias |-> s_lock);

  // R9
  word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && c_alias && (WORD_ONLY != 0) |-> c_size == 2'd2);
endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ALIAS_BASE  (ALIAS_BASE),
  .TARGET_BYTES(TARGET_BYTES),
  .WORD_ONLY   (WORD_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
  .m_req_addr(m_req_addr), .m_req_write(m_req_write), .m_req_size(m_req_size),
  .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata),
  .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
  .s_req_addr(s_req_addr), .s_req_write(s_req_write), .s_req_size(s_req_size),
  .s_req_wdata(s_req_wdata), .s_lock(s_lock)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] AB = 32'h2200_0000;
  localparam logic [31:0] TB = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // main instance signals
  logic        m_req_valid = 1'b0, m_req_write = 1'b0;
  logic [31:0] m_req_addr = '0, m_req_wdata = '0;
  logic [1:0]  m_req_size = 2'd2;
  logic        m_req_ready, m_rsp_valid, m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic        s_req_valid, s_req_ready, s_req_write, s_lock;
  logic [31:0] s_req_addr, s_req_wdata;
  logic [1:0]  s_req_size;
  logic        s_rsp_valid, s_rsp_err;
  logic [31:0] s_rsp_rdata;

  bitband_bridge #(.ALIAS_BASE(AB), .TARGET_BASE(TB), .TARGET_BYTES(256), .WORD_ONLY(0))
  i_bitband_bridge (
    .clk, .rst_n, .m_req_valid, .m_req_ready, .m_req_addr, .m_req_write,
    .m_req_size, .m_req_wdata, .m_rsp_valid, .m_rsp_rdata, .m_rsp_err,
    .s_req_valid, .s_req_ready, .s_req_addr, .s_req_write, .s_req_size,
    .s_req_wdata, .s_lock, .s_rsp_valid, .s_rsp_rdata, .s_rsp_err);

  // target memory model with stalls and an error band at offsets 0xF0..0xFF
  logic [7:0]  mem [256];
  logic [7:0]  lfsr;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [1:0]  last_rd_size, last_wr_size;
  logic        last_wr_lock;
  int          wr_count;

  assign s_req_ready = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      lfsr <= 8'h5B;
      s_rsp_valid <= 1'b0;
      s_rsp_err <= 1'b0;
      s_rsp_rdata <= '0;
      wr_count <= 0;
      last_rd_addr <= '0; last_wr_addr <= '0;
      last_rd_size <= '0; last_wr_size <= '0; last_wr_lock <= 1'b0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      s_rsp_valid <= 1'b0;
      if (s_req_valid && s_req_ready) begin
        logic [7:0] a;
        logic       bad;
        a   = s_req_addr[7:0];
        bad = (a[7:4] == 4'hF);
        s_rsp_valid <= 1'b1;
        s_rsp_err <= bad;
        s_rsp_rdata <= {mem[a + 8'd3], mem[a + 8'd2], mem[a + 8'd1], mem[a]} &
                       (s_req_size == 2'd0 ? 32'hFF : s_req_size == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF);
        if (s_req_write) begin
          last_wr_addr <= s_req_addr; last_wr_size <= s_req_size; last_wr_lock <= s_lock;
          wr_count <= wr_count + 1;
          if (!bad) begin
            mem[a] <= s_req_wdata[7:0];
            if (s_req_size != 2'd0) mem[a + 8'd1] <= s_req_wdata[15:8];
            if (s_req_size == 2'd2) begin
              mem[a + 8'd2] <= s_req_wdata[23:16];
              mem[a + 8'd3] <= s_req_wdata[31:24];
            end
          end
        end else begin
          last_rd_addr <= s_req_addr; last_rd_size <= s_req_size;
        end
      end
    end
  end

  // word-only instance
  logic        w_req_valid = 1'b0;
  logic [31:0] w_req_addr = '0;
  logic        w_req_write = 1'b0;
  logic [1:0]  w_req_size = 2'd2;
  logic        w_req_ready, w_rsp_valid, w_rsp_err;
  logic [31:0] w_rsp_rdata;
  logic        ws_req_valid, ws_req_write, ws_lock, ws_rsp_valid;
  logic [31:0] ws_req_addr, ws_req_wdata;
  logic [1:0]  ws_req_size;
  int          ws_count;

  bitband_bridge #(.ALIAS_BASE(AB), .TARGET_BASE(TB), .TARGET_BYTES(256), .WORD_ONLY(1))
  i_bitband_bridge_wo (
    .clk, .rst_n, .m_req_valid(w_req_valid), .m_req_ready(w_req_ready),
    .m_req_addr(w_req_addr), .m_req_write(w_req_write), .m_req_size(w_req_size),
    .m_req_wdata(32'd1), .m_rsp_valid(w_rsp_valid), .m_rsp_rdata(w_rsp_rdata),
    .m_rsp_err(w_rsp_err), .s_req_valid(ws_req_valid), .s_req_ready(1'b1),
    .s_req_addr(ws_req_addr), .s_req_write(ws_req_write), .s_req_size(ws_req_size),
    .s_req_wdata(ws_req_wdata), .s_lock(ws_lock), .s_rsp_valid(ws_rsp_valid),
    .s_rsp_rdata(32'd0), .s_rsp_err(1'b0));

  always @(posedge clk) begin
    if (!rst_n) begin
      ws_rsp_valid <= 1'b0;
      ws_count <= 0;
    end else begin
      ws_rsp_valid <= ws_req_valid;
      if (ws_req_valid) ws_count <= ws_count + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_data_q[$];
  logic        exp_err_q[$];
  string       exp_tag_q[$];

  always @(negedge clk) begin
    if (rst_n && m_rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        check("R7 unexpected response", 32'd1, 32'd0);
      end else begin
        string       t;
        logic [31:0] d;
        logic        e;
        t = exp_tag_q.pop_front();
        d = exp_data_q.pop_front();
        e = exp_err_q.pop_front();
        check({t, " rdata"}, m_rsp_rdata, d);
        check({t, " err"}, {31'd0, m_rsp_err}, {31'd0, e});
      end
    end
  end

  task automatic send(input logic [31:0] addr, input logic wr, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [31:0] exp_d,
                      input logic exp_e, input string tag);
    exp_data_q.push_back(exp_d);
    exp_err_q.push_back(exp_e);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    m_req_addr = addr; m_req_write = wr; m_req_size = sz; m_req_wdata = wd;
    m_req_valid = 1'b1;
    while (!m_req_ready) @(negedge clk);
    @(posedge clk);
    #1 m_req_valid = 1'b0;
    while (exp_data_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 m_req_ready", {31'd0, m_req_ready}, 32'd1);
    check("R11 m_rsp_valid", {31'd0, m_rsp_valid}, 32'd0);
    check("R11 s_req_valid", {31'd0, s_req_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 passthrough
    send(TB + 32'h10, 1'b1, 2'd2, 32'hA5A5_0F0F, 32'd0, 1'b0, "R1 pass write");
    check("R1 pass wr addr", last_wr_addr, TB + 32'h10);
    send(TB + 32'h10, 1'b0, 2'd2, 32'd0, 32'hA5A5_0F0F, 1'b0, "R1 pass read word");
    send(TB + 32'h11, 1'b0, 2'd0, 32'd0, 32'h0F, 1'b0, "R1 pass read byte");
    check("R1 pass rd size", {30'd0, last_rd_size}, 32'd0);
    send(TB + 32'h12, 1'b0, 2'd0, 32'd0, 32'hA5, 1'b0, "R1 pass read byte hi");

    // R2 R3 alias word reads: word 0x10 -> alias offset 0x200
    send(AB + 32'h220, 1'b0, 2'd2, 32'd0, 32'd1, 1'b0, "R3 alias read bit8");
    check("R2 alias read addr", last_rd_addr, TB + 32'h10);
    send(AB + 32'h210, 1'b0, 2'd2, 32'd0, 32'd0, 1'b0, "R3 alias read bit4");

    // R4 clear bit8 with other wdata bits set, then set bit4
    send(AB + 32'h220, 1'b1, 2'd2, 32'hFFFF_FFFE, 32'd0, 1'b0, "R4 alias clear");
    send(TB + 32'h10, 1'b0, 2'd2, 32'd0, 32'hA5A5_0E0F, 1'b0, "R4 after clear");
    send(AB + 32'h210, 1'b1, 2'd2, 32'd1, 32'd0, 1'b0, "R4 alias set");
    send(TB + 32'h10, 1'b0, 2'd2, 32'd0, 32'hA5A5_0E1F, 1'b0, "R4 after set");

    // R6 R5 R7 byte alias clear of bit9 -> byte 0x11 bit1
    send(AB + 32'h224, 1'b1, 2'd0, 32'd0, 32'd0, 1'b0, "R6 byte clear");
    check("R6 byte rd addr", last_rd_addr, TB + 32'h11);
    check("R6 byte wr addr", last_wr_addr, TB + 32'h11);
    check("R5 byte wr size", {30'd0, last_wr_size}, 32'd0);
    check("R7 lock on write-back", {31'd0, last_wr_lock}, 32'd1);
    send(TB + 32'h10, 1'b0, 2'd2, 32'd0, 32'hA5A5_0C1F, 1'b0, "R6 after byte clear");

    // R6 halfword alias set of bit20 -> halfword 0x12 bit4
    send(AB + 32'h250, 1'b1, 2'd1, 32'd1, 32'd0, 1'b0, "R6 half set");
    check("R6 half wr addr", last_wr_addr, TB + 32'h12);
    check("R5 half wr size", {30'd0, last_wr_size}, 32'd1);
    send(AB + 32'h250, 1'b0, 2'd0, 32'd0, 32'd1, 1'b0, "R3 byte alias read bit20");
    check("R6 byte rd addr bit20", last_rd_addr, TB + 32'h12);
    send(TB + 32'h10, 1'b0, 2'd2, 32'd0, 32'hA5B5_0C1F, 1'b0, "R4 final word");

    // R8 read-phase error aborts write-back (word 0xF0 -> alias offset 0x1E00)
    wc = wr_count;
    send(AB + 32'h1E00, 1'b1, 2'd2, 32'd1, 32'd0, 1'b1, "R8 aborted rmw");
    check("R8 no write-back", wr_count, wc);
    send(TB + 32'hF4, 1'b0, 2'd2, 32'd0, 32'd0, 1'b1, "R1 pass error");

    // R9 word-only instance
    @(negedge clk);
    w_req_addr = AB + 32'h224; w_req_write = 1'b1; w_req_size = 2'd0; w_req_valid = 1'b1;
    @(posedge clk); #1 w_req_valid = 1'b0;
    while (!w_rsp_valid) @(negedge clk);
    check("R9 narrow err", {31'd0, w_rsp_err}, 32'd1);
    check("R9 narrow rdata", w_rsp_rdata, 32'd0);
    repeat (2) @(negedge clk);
    check("R9 no target request", ws_count, 0);
    w_req_size = 2'd2; w_req_write = 1'b0; w_req_valid = 1'b1;
    @(posedge clk); #1 w_req_valid = 1'b0;
    while (!w_rsp_valid) @(negedge clk);
    check("R9 word alias err", {31'd0, w_rsp_err}, 32'd0);
    check("R9 word alias reaches target", ws_count, 1);

    repeat (3) @(negedge clk);
    check("R7 responses drained", exp_data_q.size(), 0);
    finish_run();
  end
endmodule